// File: doc/BRIEF.md
# Dead-Band Complementary PWM Generator

This block drives a pulse-width-modulated output together with its complement for a half-bridge or full-bridge power stage. A 10-bit period value sets the length of each cycle, a 10-bit duty value sets how many ticks the main output stays high, and a 4-bit dead value sets a guard interval. During that interval both outputs are low, on both sides of the complementary pulse.

All timing advances on a tick enable, which a divider elsewhere derives from the system clock. Three down-counters hold the cycle position: one for the period, one for the duty and one for the dead time. When the period counter reaches zero, all three reload together from the configuration inputs. A value written in the middle of a cycle therefore only shapes the next cycle, and a running pulse is never cut short.

Top module: `pwm_db_gen`

## Requirements
- R1: While `rst` is high at a rising clock edge, every counter and the latched dead value clear to zero, and both outputs read low after that edge. The first tick after reset starts a cycle by loading the configuration.
- R2: On a clock edge where `tick` is low, no counter changes and both outputs keep their values.
- R3: A tick seen while the period count is zero loads `period_in`. Any other tick lowers the period count by one. One cycle therefore lasts `period_in`+1 ticks.
- R4: `pwm_hi` is high for the first `duty_in` ticks of a cycle, counted from the loading tick. If `duty_in` is greater than `period_in`, `pwm_hi` stays high for the whole cycle.
- R5: If `duty_in` is zero when a cycle is loaded, `pwm_hi` stays low for that whole cycle.
- R6: The dead counter decrements only on ticks where the duty count is already zero. `pwm_lo` can be high only when both the duty count and the dead count are zero. This gives a gap of `dead_in` ticks after `pwm_hi` falls.
- R7: `pwm_lo` is low whenever the period count is at or below the dead value latched at the last load. This gives a trailing gap of that value plus one tick before `pwm_hi` rises again.
- R8: `pwm_hi` and `pwm_lo` are never high in the same clock cycle.
- R9: A change to `period_in`, `duty_in` or `dead_in` during a cycle has no effect on the outputs until the next load.
- R10: With `period_in` zero, every tick loads a new cycle of one tick. `pwm_hi` then equals (`duty_in` != 0) and `pwm_lo` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Counter advance enable, one clock cycle wide per slow step |
| period_in | input | 10 | Cycle length minus one, in ticks |
| duty_in | input | 10 | High time of `pwm_hi`, in ticks |
| dead_in | input | 4 | Guard interval, in ticks |
| pwm_hi | output | 1 | Main PWM output |
| pwm_lo | output | 1 | Complementary PWM output |

## Verification
The embedded properties assume only a synchronous reset held across at least one rising edge. They also assume the dead field is narrower than the period field. They accept a configuration that changes on any cycle and a tick of any pattern, including one held high continuously. The stimulus changes inputs only at the falling edge. It covers tick held high, tick sparse and irregular, and configuration changes mid-cycle. It also covers the boundary values zero duty, duty above period, zero period, zero dead time, maximum dead time and maximum period.

// File: rtl/pwm_db_pkg.sv
package pwm_db_pkg;

    localparam int unsigned DEF_PER_W = 10;
    localparam int unsigned DEF_DZ_W  = 4;

    // Which output, if any, the current cycle position drives
    typedef enum logic [1:0] {
        PH_BLANK = 2'd0,
        PH_HIGH  = 2'd1,
        PH_LOW   = 2'd2
    } phase_e;

    function automatic logic drives_hi(input phase_e ph);
        return ph == PH_HIGH;
    endfunction

    function automatic logic drives_lo(input phase_e ph);
        return ph == PH_LOW;
    endfunction

endpackage

// File: rtl/pwm_db_period_ctr.sv
module pwm_db_period_ctr #(
    parameter int unsigned W = 10
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] cnt,
    output logic         reload
);

    assign reload = tick && (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (reload)
            cnt <= load_val;
        else if (tick)
            cnt <= cnt - 1'b1;
    end

    assert_reload_value_R3: assert property (@(posedge clk) disable iff (rst)
        reload |=> cnt == $past(load_val));

    assert_count_step_R3: assert property (@(posedge clk) disable iff (rst)
        (tick && cnt != '0) |=> cnt == W'($past(cnt) - 1'b1));

    assert_idle_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(cnt));

endmodule

// File: rtl/pwm_db_hold_ctr.sv
module pwm_db_hold_ctr #(
    parameter int unsigned W = 10
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         reload,
    input  logic         step,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] cnt,
    output logic         zero
);

    assign zero = (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (reload)
            cnt <= load_val;
        else if (step && !zero)
            cnt <= cnt - 1'b1;
    end

    assert_hold_at_zero_R6: assert property (@(posedge clk) disable iff (rst)
        (zero && !reload) |=> zero);

    assert_no_step_R2: assert property (@(posedge clk) disable iff (rst)
        (!reload && !step) |=> $stable(cnt));

endmodule

// File: rtl/pwm_db_out_dec.sv
module pwm_db_out_dec
    import pwm_db_pkg::*;
#(
    parameter int unsigned PER_W = 10,
    parameter int unsigned DZ_W  = 4
) (
    input  logic [PER_W-1:0] pcnt,
    input  logic [DZ_W-1:0]  dead_lat,
    input  logic             duty_zero,
    input  logic             dead_zero,
    output logic             hi,
    output logic             lo
);

    localparam int unsigned PAD = PER_W - DZ_W;

    logic [PER_W-1:0] dead_wide;
    phase_e           phase;

    assign dead_wide = {{PAD{1'b0}}, dead_lat};

    always_comb begin
        if (!duty_zero)
            phase = PH_HIGH;
        else if (!dead_zero)
            phase = PH_BLANK;
        else if (pcnt > dead_wide)
            phase = PH_LOW;
        else
            phase = PH_BLANK;
    end

    assign hi = drives_hi(phase);
    assign lo = drives_lo(phase);

endmodule

// File: rtl/pwm_db_gen.sv
module pwm_db_gen
    import pwm_db_pkg::*;
#(
    parameter int unsigned PER_W = DEF_PER_W,
    parameter int unsigned DZ_W  = DEF_DZ_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic [PER_W-1:0] period_in,
    input  logic [PER_W-1:0] duty_in,
    input  logic [DZ_W-1:0]  dead_in,
    output logic             pwm_hi,
    output logic             pwm_lo
);

    logic [PER_W-1:0] pcnt;
    logic [PER_W-1:0] dcnt;
    logic [DZ_W-1:0]  zcnt;
    logic [DZ_W-1:0]  dead_lat;
    logic             reload;
    logic             duty_zero;
    logic             dead_zero;

    pwm_db_period_ctr #(.W(PER_W)) u_period (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .load_val (period_in),
        .cnt      (pcnt),
        .reload   (reload)
    );

    pwm_db_hold_ctr #(.W(PER_W)) u_duty (
        .clk      (clk),
        .rst      (rst),
        .reload   (reload),
        .step     (tick),
        .load_val (duty_in),
        .cnt      (dcnt),
        .zero     (duty_zero)
    );

    // dead interval only runs once the duty interval has expired
    pwm_db_hold_ctr #(.W(DZ_W)) u_dead (
        .clk      (clk),
        .rst      (rst),
        .reload   (reload),
        .step     (tick && duty_zero),
        .load_val (dead_in),
        .cnt      (zcnt),
        .zero     (dead_zero)
    );

    // snapshot of the guard value used for the trailing gap
    always_ff @(posedge clk) begin
        if (rst)
            dead_lat <= '0;
        else if (reload)
            dead_lat <= dead_in;
    end

    pwm_db_out_dec #(.PER_W(PER_W), .DZ_W(DZ_W)) u_dec (
        .pcnt      (pcnt),
        .dead_lat  (dead_lat),
        .duty_zero (duty_zero),
        .dead_zero (dead_zero),
        .hi        (pwm_hi),
        .lo        (pwm_lo)
    );

    assert_hi_rise_on_load_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(pwm_hi) |-> $past(reload));

    assert_duty_zero_low_R5: assert property (@(posedge clk) disable iff (rst)
        (reload && duty_in == '0) |=> !pwm_hi);

    assert_lo_after_expiry_R6: assert property (@(posedge clk) disable iff (rst)
        pwm_lo |-> (duty_zero && dead_zero));

    assert_lat_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !reload |=> $stable(dead_lat));

    assert_zero_period_R10: assert property (@(posedge clk) disable iff (rst)
        (reload && period_in == '0) |=> !pwm_lo);

endmodule

// File: tb/pwm_db_gen_bench.sv
module pwm_db_gen_bench;

    logic       clk = 1'b0;
    logic       rst;
    logic       tick;
    logic [9:0] period_in;
    logic [9:0] duty_in;
    logic [3:0] dead_in;
    logic       pwm_hi;
    logic       pwm_lo;

    int  checks = 0;
    int  errors = 0;
    bit  done   = 0;

    // behavioural reference: position within the cycle and the loaded values
    int  m_p, m_d, m_z, m_k;
    bit  m_run;

    always #5 clk = ~clk;

    pwm_db_gen u_pwm_db_gen (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .period_in (period_in),
        .duty_in   (duty_in),
        .dead_in   (dead_in),
        .pwm_hi    (pwm_hi),
        .pwm_lo    (pwm_lo)
    );

    function automatic bit exp_hi();
        return m_run && (m_k < m_d);
    endfunction

    function automatic bit exp_lo();
        return m_run && (m_k >= m_d + m_z) && ((m_p - m_k) > m_z);
    endfunction

    task automatic model_edge();
        if (rst) begin
            m_run = 0; m_p = 0; m_d = 0; m_z = 0; m_k = 0;
        end else if (tick) begin
            if (!m_run || m_k == m_p) begin
                m_p = int'(period_in); m_d = int'(duty_in); m_z = int'(dead_in);
                m_k = 0; m_run = 1;
            end else begin
                m_k = m_k + 1;
            end
        end
    endtask

    task automatic compare(input string tag);
        bit eh, el;
        eh = exp_hi();
        el = exp_lo();
        checks += 3;
        if (pwm_hi !== eh) begin
            errors++;
            $display("FAIL %s pwm_hi actual=%b expected=%b at %0t", tag, pwm_hi, eh, $time);
        end
        if (pwm_lo !== el) begin
            errors++;
            $display("FAIL %s pwm_lo actual=%b expected=%b at %0t", tag, pwm_lo, el, $time);
        end
        if (pwm_hi === 1'b1 && pwm_lo === 1'b1) begin
            errors++;
            $display("FAIL R8 overlap actual=11 expected=not both high at %0t", $time);
        end
    endtask

    // called at a falling edge: apply inputs, take one rising edge, check at next falling edge
    task automatic step(input bit t, input string tag);
        tick = t;
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare(tag);
    endtask

    task automatic set_cfg(input int p, input int d, input int z);
        period_in = 10'(p);
        duty_in   = 10'(d);
        dead_in   = 4'(z);
    endtask

    task automatic run(input int n, input string tag);
        for (int i = 0; i < n; i++) step(1'b1, tag);
    endtask

    initial begin
        rst = 1'b1;
        tick = 1'b1;
        set_cfg(20, 8, 3);
        @(negedge clk);
        for (int i = 0; i < 3; i++) step(1'b1, "R1");
        rst = 1'b0;
        step(1'b0, "R1");
        step(1'b0, "R1");

        // continuous tick, several full cycles
        set_cfg(20, 8, 3);
        run(70, "R3");
        set_cfg(20, 8, 3);
        run(10, "R6");
        run(20, "R7");

        // sparse tick with configuration wiggling while idle
        for (int i = 0; i < 120; i++) begin
            if (i % 3 != 0) set_cfg(i, 200 - i, i % 16);
            else            set_cfg(20, 8, 3);
            step(i % 3 == 0, "R2");
        end
        set_cfg(20, 8, 3);
        for (int i = 0; i < 90; i++) step((i % 7 == 1) || (i % 5 == 2), "R2");

        // zero duty
        set_cfg(15, 0, 2);
        run(50, "R5");

        // duty beyond period
        set_cfg(12, 30, 4);
        run(45, "R4");
        set_cfg(12, 5, 0);
        run(40, "R4");

        // mid-cycle changes must wait for the next load
        set_cfg(30, 10, 5);
        run(31, "R9");
        for (int i = 0; i < 31; i++) begin
            set_cfg(3 + i % 4, (i * 7) % 40, 15 - (i % 16));
            step(1'b1, "R9");
        end
        set_cfg(30, 10, 5);
        run(70, "R9");

        // zero period
        set_cfg(0, 4, 3);
        run(12, "R10");
        set_cfg(0, 0, 3);
        run(8, "R10");

        // extreme dead values
        set_cfg(40, 10, 15);
        run(90, "R6");
        set_cfg(40, 10, 0);
        run(90, "R7");
        set_cfg(10, 3, 15);
        run(40, "R7");

        // maximum period
        set_cfg(1023, 500, 9);
        run(2100, "R3");

        // reset in the middle of a cycle
        set_cfg(20, 8, 3);
        run(10, "R1");
        rst = 1'b1;
        step(1'b1, "R1");
        rst = 1'b0;
        run(45, "R1");

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #1500000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R3 watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule